// File: doc/BRIEF.md
# Indexed Sequencer and Graphics Register Bank

This block holds the extended registers of a display controller behind an index/data pair. The host picks a register with an 8-bit index written to one of two index ports, one for the sequencer space and one for the graphics space. It then reads or writes that register through the matching data port. Each data access takes one cycle. Read data comes out of a register one cycle after the read strobe.

In the graphics space, the background and foreground colour registers are held in dedicated shadow flops. These are the values sent to the pixel expander. The sequencer space stores the extension-unlock register, a bank of extended control registers, and the cursor position pair. The cursor X register answers at eight indices and the cursor Y register answers at seven. Indices with no storage read as zero and ignore writes.

Top module: `ext_reg_bank`

## Requirements
- R1: After reset every stored register, both index registers and the read data output are zero.
- R2: A write to an index port loads that 8-bit index, and the index keeps its value through any number of data-port accesses.
- R3: A graphics-space write at index 0x00 updates the background shadow and a write at 0x01 updates the foreground shadow. A read at either index returns that shadow value.
- R4: bg_color_o and fg_color_o always present the background and foreground shadow registers, so they change in the cycle after the write.
- R5: A sequencer read at index 0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0 or 0xF0 returns cursor X, and a sequencer write at any of those indices updates cursor X.
- R6: A sequencer read or write at index 0x11, 0x31, 0x51, 0x71, 0x91, 0xB1 or 0xD1 accesses cursor Y. Index 0xF1 is not an alias; it has its own storage.
- R7: Sequencer index 0x06 (extension unlock) reads back the value last written to it.
- R8: Sequencer indices 0x07 to 0x0F, 0x12, 0x13 and 0xF1 each store and read back their own value, independently of one another.
- R9: Read data is valid on rdata_o in the cycle after a data read strobe and holds until the next read. Indices without storage read as 0x00, and writes to them change no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seq_idx_we_i | input | 1 | Load sequencer index |
| gfx_idx_we_i | input | 1 | Load graphics index |
| idx_i | input | 8 | Index value to load |
| seq_we_i | input | 1 | Sequencer data write |
| seq_re_i | input | 1 | Sequencer data read |
| gfx_we_i | input | 1 | Graphics data write |
| gfx_re_i | input | 1 | Graphics data read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| seq_idx_o | output | 8 | Current sequencer index |
| gfx_idx_o | output | 8 | Current graphics index |
| bg_color_o | output | 8 | Background colour to pixel expander |
| fg_color_o | output | 8 | Foreground colour to pixel expander |

## Verification
The hardest case to reach is a write made through one alias, for example 0xB1, followed by a read through a different alias such as 0x51. A read of 0xF1 must also be shown to stay apart from cursor Y. Random stimulus only rarely lands on these pairs. The bench therefore mixes random indices with an index pool biased toward the alias sets, the unlock and extended registers, the colour indices and unmapped indices. It keeps a reference model of the stored registers and compares every read against it. Directed sequences then write through each alias and read through every other one.

// File: rtl/ext_reg_pkg.sv
package ext_reg_pkg;
  localparam int DW = 8;
  localparam int IW = 8;
  localparam int NEXT = 9;          // extended regs 0x07..0x0F
  localparam logic [IW-1:0] EXT_BASE = 8'h07;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_UNLOCK, SEL_EXT, SEL_CURX, SEL_CURY,
    SEL_ATTR, SEL_PAT, SEL_CY2
  } seq_sel_e;

  function automatic seq_sel_e seq_decode(input logic [IW-1:0] idx);
    if (idx[4:0] == 5'h10) return SEL_CURX;
    if (idx[4:0] == 5'h11 && idx != 8'hF1) return SEL_CURY;
    if (idx == 8'hF1) return SEL_CY2;
    if (idx == 8'h06) return SEL_UNLOCK;
    if (idx >= 8'h07 && idx <= 8'h0F) return SEL_EXT;
    if (idx == 8'h12) return SEL_ATTR;
    if (idx == 8'h13) return SEL_PAT;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/idx_reg.sv
module idx_reg #(
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] d_i,
  input  logic          data_acc_i,
  output logic [IW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else if (we_i) q_o <= d_i;

  p_idx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && data_acc_i) |=> $stable(q_o));
endmodule

// File: rtl/seq_space.sv
module seq_space
  import ext_reg_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8,
  parameter int NX = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_o
);
  localparam int XW = $clog2(NX);
  seq_sel_e sel;
  logic [DW-1:0] unlock_q, curx_q, cury_q, attr_q, pat_q, cy2_q;
  logic [DW-1:0] ext_q [NX];
  logic [IW-1:0] ext_off;

  assign sel = seq_decode(idx_i);
  assign ext_off = idx_i - EXT_BASE;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      unlock_q <= '0; curx_q <= '0; cury_q <= '0;
      attr_q <= '0; pat_q <= '0; cy2_q <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_UNLOCK: unlock_q <= wdata_i;
        SEL_CURX:   curx_q   <= wdata_i;
        SEL_CURY:   cury_q   <= wdata_i;
        SEL_ATTR:   attr_q   <= wdata_i;
        SEL_PAT:    pat_q    <= wdata_i;
        SEL_CY2:    cy2_q    <= wdata_i;
        default: ;
      endcase
    end

  for (genvar g = 0; g < NX; g++) begin : g_ext
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) ext_q[g] <= '0;
      else if (we_i && sel == SEL_EXT && ext_off == IW'(g)) ext_q[g] <= wdata_i;
  end

  always_comb begin
    case (sel)
      SEL_UNLOCK: rd_o = unlock_q;
      SEL_EXT:    rd_o = ext_q[ext_off[XW-1:0]];
      SEL_CURX:   rd_o = curx_q;
      SEL_CURY:   rd_o = cury_q;
      SEL_ATTR:   rd_o = attr_q;
      SEL_PAT:    rd_o = pat_q;
      SEL_CY2:    rd_o = cy2_q;
      default:    rd_o = '0;
    endcase
  end

  p_curx_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i[4:0] == 5'h10) |=> (curx_q == $past(wdata_i)));
  p_f1_sep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == 8'hF1) |=> $stable(cury_q));
  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_NONE) |=> ($stable(curx_q) && $stable(cury_q) && $stable(unlock_q)));
endmodule

// File: rtl/gfx_space.sv
module gfx_space #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_o,
  output logic [DW-1:0] bg_o,
  output logic [DW-1:0] fg_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bg_o <= '0; fg_o <= '0;
    end else if (we_i) begin
      if (idx_i == 8'h00) bg_o <= wdata_i;
      if (idx_i == 8'h01) fg_o <= wdata_i;
    end

  always_comb
    case (idx_i)
      8'h00:   rd_o = bg_o;
      8'h01:   rd_o = fg_o;
      default: rd_o = '0;
    endcase

  p_bg_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == 8'h00) |=> (bg_o == $past(wdata_i)));
  p_fg_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == 8'h01) |=> (fg_o == $past(wdata_i)));
  p_fg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && idx_i == 8'h01) |=> $stable(fg_o));
endmodule

// File: rtl/ext_reg_bank.sv
module ext_reg_bank
  import ext_reg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seq_idx_we_i,
  input  logic          gfx_idx_we_i,
  input  logic [IW-1:0] idx_i,
  input  logic          seq_we_i,
  input  logic          seq_re_i,
  input  logic          gfx_we_i,
  input  logic          gfx_re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [IW-1:0] seq_idx_o,
  output logic [IW-1:0] gfx_idx_o,
  output logic [DW-1:0] bg_color_o,
  output logic [DW-1:0] fg_color_o
);
  logic [DW-1:0] seq_rd, gfx_rd;

  idx_reg #(.IW(IW)) u_seq_idx (.clk_i, .rst_ni, .we_i(seq_idx_we_i), .d_i(idx_i),
    .data_acc_i(seq_we_i | seq_re_i), .q_o(seq_idx_o));
  idx_reg #(.IW(IW)) u_gfx_idx (.clk_i, .rst_ni, .we_i(gfx_idx_we_i), .d_i(idx_i),
    .data_acc_i(gfx_we_i | gfx_re_i), .q_o(gfx_idx_o));

  seq_space #(.DW(DW), .IW(IW), .NX(NEXT)) u_seq (.clk_i, .rst_ni, .idx_i(seq_idx_o),
    .we_i(seq_we_i), .wdata_i, .rd_o(seq_rd));
  gfx_space #(.DW(DW), .IW(IW)) u_gfx (.clk_i, .rst_ni, .idx_i(gfx_idx_o),
    .we_i(gfx_we_i), .wdata_i, .rd_o(gfx_rd), .bg_o(bg_color_o), .fg_o(fg_color_o));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else if (seq_re_i) rdata_o <= seq_rd;
    else if (gfx_re_i) rdata_o <= gfx_rd;

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_re_i || gfx_re_i) |=> $stable(rdata_o));
endmodule

// File: tb/tb_ext_reg_bank.sv
module tb_ext_reg_bank;
  logic clk = 0, rst_ni = 0;
  logic seq_idx_we = 0, gfx_idx_we = 0, seq_we = 0, seq_re = 0, gfx_we = 0, gfx_re = 0;
  logic [7:0] idx = 0, wdata = 0;
  logic [7:0] rdata, seq_idx, gfx_idx, bg, fg;
  int total = 0, bad = 0, cyc = 0;
  logic [7:0] mseq [256];
  logic [7:0] mbg = 0, mfg = 0;

  always #5 clk = ~clk;

  ext_reg_bank dut (.clk_i(clk), .rst_ni, .seq_idx_we_i(seq_idx_we), .gfx_idx_we_i(gfx_idx_we),
    .idx_i(idx), .seq_we_i(seq_we), .seq_re_i(seq_re), .gfx_we_i(gfx_we), .gfx_re_i(gfx_re),
    .wdata_i(wdata), .rdata_o(rdata), .seq_idx_o(seq_idx), .gfx_idx_o(gfx_idx),
    .bg_color_o(bg), .fg_color_o(fg));

  // storage slot for a sequencer index; 0 means no storage
  function automatic int slot(input logic [7:0] i);
    if (i[4:0] == 5'h10) return 8'h10;
    if (i == 8'hF1) return 8'hF1;
    if (i[4:0] == 5'h11) return 8'h11;
    if (i >= 8'h06 && i <= 8'h0F) return i;
    if (i == 8'h12 || i == 8'h13) return i;
    return 0;
  endfunction

  function automatic logic [7:0] exp_seq(input logic [7:0] i);
    int s = slot(i);
    return (s == 0) ? 8'h00 : mseq[s];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic seq_idx_wr(input logic [7:0] i);
    @(negedge clk); idx = i; seq_idx_we = 1; @(negedge clk); seq_idx_we = 0;
  endtask
  task automatic gfx_idx_wr(input logic [7:0] i);
    @(negedge clk); idx = i; gfx_idx_we = 1; @(negedge clk); gfx_idx_we = 0;
  endtask
  task automatic seq_wr(input logic [7:0] i, input logic [7:0] d);
    int s;
    seq_idx_wr(i);
    wdata = d; seq_we = 1; @(negedge clk); seq_we = 0;
    s = slot(i);
    if (s != 0) mseq[s] = d;
  endtask
  task automatic seq_rd(input logic [7:0] i, input string req);
    seq_idx_wr(i);
    seq_re = 1; @(negedge clk); seq_re = 0;
    chk(req, rdata, exp_seq(i));
  endtask
  task automatic gfx_wr(input logic [7:0] i, input logic [7:0] d);
    gfx_idx_wr(i);
    wdata = d; gfx_we = 1; @(negedge clk); gfx_we = 0;
    if (i == 8'h00) mbg = d;
    if (i == 8'h01) mfg = d;
  endtask
  task automatic gfx_rd(input logic [7:0] i, input string req);
    logic [7:0] e;
    gfx_idx_wr(i);
    gfx_re = 1; @(negedge clk); gfx_re = 0;
    e = (i == 8'h00) ? mbg : (i == 8'h01) ? mfg : 8'h00;
    chk(req, rdata, e);
  endtask

  function automatic logic [7:0] pick();
    logic [7:0] pool [12] = '{8'h10, 8'h30, 8'hF0, 8'h11, 8'hB1, 8'hF1,
                              8'h06, 8'h07, 8'h0F, 8'h12, 8'h13, 8'h20};
    if ($urandom_range(0, 3) == 0) return 8'($urandom);
    return pool[$urandom_range(0, 11)];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    for (int k = 0; k < 256; k++) mseq[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 0); chk("R1 bg", bg, 0); chk("R1 fg", fg, 0);
    chk("R1 seqidx", seq_idx, 0); chk("R1 gfxidx", gfx_idx, 0);
    rst_ni = 1;
    seq_rd(8'h0C, "R1 ext reset");

    gfx_wr(8'h00, 8'h5A);
    chk("R4 bg", bg, 8'h5A);
    gfx_wr(8'h01, 8'hC3);
    chk("R4 fg", fg, 8'hC3); chk("R4 bg kept", bg, 8'h5A);
    gfx_rd(8'h00, "R3 bg read"); gfx_rd(8'h01, "R3 fg read");
    gfx_wr(8'h05, 8'hFF);
    gfx_rd(8'h05, "R9 gfx unmapped");
    chk("R9 fg untouched", fg, 8'hC3);

    // index retention across data accesses
    seq_idx_wr(8'h09);
    wdata = 8'h77; seq_we = 1; @(negedge clk); seq_we = 0; mseq[9] = 8'h77;
    seq_re = 1; @(negedge clk); seq_re = 0;
    chk("R2 idx kept", seq_idx, 8'h09);
    chk("R2 read via kept idx", rdata, 8'h77);
    repeat (2) @(negedge clk);
    chk("R9 rdata hold", rdata, 8'h77);

    seq_wr(8'h06, 8'h12); seq_rd(8'h06, "R7 unlock");

    // cursor alias walk
    begin
      logic [7:0] xs [8] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};
      logic [7:0] ys [7] = '{8'h11, 8'h31, 8'h51, 8'h71, 8'h91, 8'hB1, 8'hD1};
      for (int w = 0; w < 8; w++) begin
        seq_wr(xs[w], 8'(8'h40 + w));
        for (int r = 0; r < 8; r++) seq_rd(xs[r], "R5 curx alias");
      end
      seq_wr(8'hF1, 8'hEE);
      for (int w = 0; w < 7; w++) begin
        seq_wr(ys[w], 8'(8'h80 + w));
        for (int r = 0; r < 7; r++) seq_rd(ys[r], "R6 cury alias");
        seq_rd(8'hF1, "R6 F1 separate");
      end
    end

    for (int k = 7; k <= 15; k++) seq_wr(8'(k), 8'(k * 17));
    seq_wr(8'h12, 8'hA1); seq_wr(8'h13, 8'hB2);
    for (int k = 7; k <= 15; k++) seq_rd(8'(k), "R8 ext own");
    seq_rd(8'h12, "R8 attr"); seq_rd(8'h13, "R8 pat"); seq_rd(8'hF1, "R8 F1");
    seq_wr(8'h20, 8'h99); seq_rd(8'h20, "R9 seq unmapped");
    seq_rd(8'h0A, "R9 no side effect");

    for (int n = 0; n < 400; n++) begin
      logic [7:0] i = pick();
      int op = $urandom_range(0, 3);
      case (op)
        0: seq_wr(i, 8'($urandom));
        1: seq_rd(i, "R8 random seq");
        2: gfx_wr(8'($urandom_range(0, 2)), 8'($urandom));
        default: gfx_rd(8'($urandom_range(0, 2)), "R3 random gfx");
      endcase
      chk("R4 bg track", bg, mbg);
      chk("R4 fg track", fg, mfg);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule